// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical page address for a 32-bit paging unit that uses a page directory and page tables, with optional 4 MB pages. A request carries the address and two flags: whether the access is a write and whether it comes from user code. The walker fetches the directory entry, and when needed the table entry, through a single word-wide memory port with a request/acknowledge handshake. It checks the user and write rights and writes back the accessed and dirty bits. It then reports either a physical 4 KB frame address with a write-permission flag or a page fault. A fault carries a three-bit error code and the faulting address.

Read permission is always granted. Write permission is granted only when the leaf entry is already dirty, so a clean page can be cached read-only, and the first store to it comes back through the walker to set the dirty bit. Only one walk runs at a time. The caller holds the control-register inputs and the A20 mask stable while a walk is in progress.

Top module: `pt_walker`

## Requirements
- R1: When cr0 bit 31 (paging enable) is 0, no memory access is made, the walk ends without fault, phys_page equals req_addr AND a20_mask with bits 11:0 cleared, and page_writable is 1.
- R2: The directory entry is read at ((cr3 with bits 11:0 cleared) + linear bits 31:22 × 4) AND a20_mask. The table entry is read at ((directory entry with bits 11:0 cleared) + linear bits 21:12 × 4) AND a20_mask.
- R3: A directory or table entry with bit 0 (present) equal to 0 ends the walk with a fault whose code bit 0 is 0.
- R4: A directory entry maps a 4 MB page only when its bit 7 is 1 and cr4 bit 4 is 1, and then no table entry is read. Otherwise bit 7 is ignored and the entry points to a page table.
- R5: For a 4 KB page the user right (bit 2) and the write right (bit 1) are the AND of the directory and table entries. A user access needs the user right, and a user write also needs the write right.
- R6: A supervisor read never faults on rights. A supervisor write without the write right faults only when cr0 bit 16 (write protect) is 1.
- R7: A rights violation faults with code bit 0 set. The fault code is {req_user, req_write, bit0} as bits 2, 1 and 0, and fault_addr is the requested linear address.
- R8: Every entry used in a walk gets bit 5 (accessed) set. The entry is written back only if its value changes. A directory entry that points to a table gets only the accessed bit set.
- R9: A write access sets bit 6 (dirty) in the leaf entry: the table entry, or the directory entry of a 4 MB page.
- R10: page_writable is 1 only when the leaf entry, after update, has the dirty bit set and the rights allow the write (user: write right; supervisor: write right or cr0 bit 16 clear).
- R11: For a 4 MB page, phys_page = ((entry bits 31:22, rest 0) AND a20_mask) + (linear bits 21:12 shifted left by 12). For a 4 KB page it is the table entry AND a20_mask with bits 11:0 cleared.
- R12: walk_done is high for exactly one cycle per accepted request. req_valid is ignored while a walk is in progress. A memory request holds its address until acknowledged.
- R13: After reset walk_done, walk_fault and mem_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_addr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user code |
| cr0 | input | 32 | Control register 0 (bit 31 paging, bit 16 write protect) |
| cr3 | input | 32 | Directory base register |
| cr4 | input | 32 | Control register 4 (bit 4 large pages) |
| a20_mask | input | 32 | Mask applied to every physical address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address of the entry |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Entry read from memory |
| walk_done | output | 1 | One-cycle completion pulse |
| walk_fault | output | 1 | Walk ended in a page fault (valid with walk_done) |
| phys_page | output | 32 | Physical 4 KB frame address (valid on success) |
| page_writable | output | 1 | Write permission for the returned page |
| fault_code | output | 3 | {user, write, rights-violation} |
| fault_addr | output | 32 | Faulting linear address |

## Verification
The bench targets several corner cases. The first is a clean page that is only read: a walker that granted write on the rights alone would report it writable, and later stores would never set the dirty bit. The second is a directory entry with bit 7 set while large pages are disabled: a walker that ignored cr4 would skip the table read and return the wrong frame. The third is a re-walk of an entry that is already accessed and dirty: a walker that always wrote back would issue stores the reference does not expect. The bench also clears A20 mask bit 20 so that the entry addresses alias, checks that supervisor writes change with write protect, and toggles req_valid during a walk to catch a walker that restarts.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int WORD_W        = 32;
    localparam int PG_SHIFT      = 12;
    localparam int IDX_W         = 10;
    localparam int ENT_LOG       = 2;
    localparam int VPN_W         = WORD_W - PG_SHIFT;
    localparam int LARGE_SHIFT   = PG_SHIFT + IDX_W;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t PAGE_MASK  = ~((word_t'(1) << PG_SHIFT) - word_t'(1));
    localparam word_t LARGE_MASK = ~((word_t'(1) << LARGE_SHIFT) - word_t'(1));

    // entry bit positions
    localparam int BIT_P   = 0;
    localparam int BIT_RW  = 1;
    localparam int BIT_US  = 2;
    localparam int BIT_ACC = 5;
    localparam int BIT_DRT = 6;
    localparam int BIT_PS  = 7;

    // control register bit positions
    localparam int CR0_PG  = 31;
    localparam int CR0_WP  = 16;
    localparam int CR4_PSE = 4;

    localparam word_t ACC_SET = word_t'(1) << BIT_ACC;
    localparam word_t DRT_SET = word_t'(1) << BIT_DRT;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_DIR, ST_WB_DIR, ST_RD_TBL, ST_WB_TBL, ST_OK, ST_FLT
    } walk_st_e;

    typedef struct packed {
        logic is_user;
        logic is_write;
        logic prot;
    } fcode_t;

    function automatic word_t mark_used(word_t e, logic wr);
        return e | ACC_SET | (wr ? DRT_SET : '0);
    endfunction
endpackage

// File: rtl/ptw_addr.sv
module ptw_addr
    import ptw_pkg::*;
(
    input  word_t                 cr3,
    input  word_t                 pde,
    input  word_t                 leaf,
    input  word_t                 a20,
    input  logic [VPN_W-1:0]      vpn,
    input  logic                  big,
    output word_t                 dir_addr,
    output word_t                 tbl_addr,
    output word_t                 phys
);
    word_t dir_off, tbl_off, sub_off;

    always_comb begin
        dir_off  = word_t'(vpn[VPN_W-1 -: IDX_W]) << ENT_LOG;
        tbl_off  = word_t'(vpn[IDX_W-1:0]) << ENT_LOG;
        sub_off  = word_t'(vpn[IDX_W-1:0]) << PG_SHIFT;
        dir_addr = ((cr3 & PAGE_MASK) + dir_off) & a20;
        tbl_addr = ((pde & PAGE_MASK) + tbl_off) & a20;
        if (big)
            phys = ((leaf & LARGE_MASK) & a20) + sub_off;
        else
            phys = leaf & a20 & PAGE_MASK;
    end
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm
    import ptw_pkg::*;
(
    input  word_t entry,
    input  logic  rt_rw,
    input  logic  rt_us,
    input  logic  is_user,
    input  logic  is_write,
    input  logic  wp_en,
    output logic  deny,
    output logic  wr_ok,
    output word_t upd
);
    always_comb begin
        if (is_user)
            deny = !rt_us || (is_write && !rt_rw);
        else
            deny = wp_en && is_write && !rt_rw;
        upd   = mark_used(entry, is_write);
        wr_ok = upd[BIT_DRT] && (is_user ? rt_rw : (!wp_en || rt_rw));
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic        req_write,
    input  logic        req_user,
    input  logic [31:0] cr0,
    input  logic [31:0] cr3,
    input  logic [31:0] cr4,
    input  logic [31:0] a20_mask,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        walk_done,
    output logic        walk_fault,
    output logic [31:0] phys_page,
    output logic        page_writable,
    output logic [2:0]  fault_code,
    output logic [31:0] fault_addr
);
    walk_st_e st;
    word_t    lin_q, pde_q, leaf_q, raw_q;
    logic     wr_q, usr_q, big_q, wok_q, prot_q;

    word_t    dir_addr, tbl_addr, phys;
    logic     deny, wr_ok, rt_rw, rt_us;
    word_t    upd;
    fcode_t   code;
    logic     ctl_unused;

    assign ctl_unused = ^{cr0[30:17], cr0[15:0], cr4[31:5], cr4[3:0]};

    ptw_addr u_addr (
        .cr3      (cr3),
        .pde      (pde_q),
        .leaf     (leaf_q),
        .a20      (a20_mask),
        .vpn      (lin_q[WORD_W-1:PG_SHIFT]),
        .big      (big_q),
        .dir_addr (dir_addr),
        .tbl_addr (tbl_addr),
        .phys     (phys)
    );

    // rights of a 4 KB leaf combine both levels
    always_comb begin
        rt_rw = mem_rdata[BIT_RW] & ((st == ST_RD_TBL) ? pde_q[BIT_RW] : 1'b1);
        rt_us = mem_rdata[BIT_US] & ((st == ST_RD_TBL) ? pde_q[BIT_US] : 1'b1);
    end

    ptw_perm u_perm (
        .entry    (mem_rdata),
        .rt_rw    (rt_rw),
        .rt_us    (rt_us),
        .is_user  (usr_q),
        .is_write (wr_q),
        .wp_en    (cr0[CR0_WP]),
        .deny     (deny),
        .wr_ok    (wr_ok),
        .upd      (upd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            lin_q  <= '0;
            pde_q  <= '0;
            leaf_q <= '0;
            raw_q  <= '0;
            wr_q   <= 1'b0;
            usr_q  <= 1'b0;
            big_q  <= 1'b0;
            wok_q  <= 1'b0;
            prot_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    lin_q  <= req_addr;
                    wr_q   <= req_write;
                    usr_q  <= req_user;
                    prot_q <= 1'b0;
                    big_q  <= 1'b0;
                    if (!cr0[CR0_PG]) begin
                        leaf_q <= req_addr;
                        wok_q  <= 1'b1;
                        st     <= ST_OK;
                    end else begin
                        st <= ST_RD_DIR;
                    end
                end
                ST_RD_DIR: if (mem_ack) begin
                    raw_q <= mem_rdata;
                    if (!mem_rdata[BIT_P]) begin
                        st <= ST_FLT;
                    end else if (mem_rdata[BIT_PS] && cr4[CR4_PSE]) begin
                        big_q <= 1'b1;
                        if (deny) begin
                            prot_q <= 1'b1;
                            st     <= ST_FLT;
                        end else begin
                            pde_q  <= upd;
                            leaf_q <= upd;
                            wok_q  <= wr_ok;
                            st     <= (upd != mem_rdata) ? ST_WB_DIR : ST_OK;
                        end
                    end else begin
                        pde_q <= mem_rdata | ACC_SET;
                        st    <= mem_rdata[BIT_ACC] ? ST_RD_TBL : ST_WB_DIR;
                    end
                end
                ST_WB_DIR: if (mem_ack) st <= big_q ? ST_OK : ST_RD_TBL;
                ST_RD_TBL: if (mem_ack) begin
                    raw_q <= mem_rdata;
                    if (!mem_rdata[BIT_P]) begin
                        st <= ST_FLT;
                    end else if (deny) begin
                        prot_q <= 1'b1;
                        st     <= ST_FLT;
                    end else begin
                        leaf_q <= upd;
                        wok_q  <= wr_ok;
                        st     <= (upd != mem_rdata) ? ST_WB_TBL : ST_OK;
                    end
                end
                ST_WB_TBL: if (mem_ack) st <= ST_OK;
                default:   st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = (st == ST_RD_DIR) || (st == ST_WB_DIR) ||
                    (st == ST_RD_TBL) || (st == ST_WB_TBL);
        mem_we    = (st == ST_WB_DIR) || (st == ST_WB_TBL);
        mem_addr  = ((st == ST_RD_DIR) || (st == ST_WB_DIR)) ? dir_addr : tbl_addr;
        mem_wdata = (st == ST_WB_DIR) ? pde_q : leaf_q;
        code      = '{is_user: usr_q, is_write: wr_q, prot: prot_q};
    end

    assign walk_done     = (st == ST_OK) || (st == ST_FLT);
    assign walk_fault    = (st == ST_FLT);
    assign phys_page     = phys;
    assign page_writable = wok_q;
    assign fault_code    = code;
    assign fault_addr    = lin_q;

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        walk_done |=> !walk_done);

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8
    wb_superset_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ((mem_wdata & raw_q) == raw_q) && mem_wdata[BIT_ACC]);

    // R1
    unpaged_rw_chk: assert property (@(posedge clk) disable iff (rst)
        (walk_done && !walk_fault && !cr0[CR0_PG]) |-> page_writable);

    // R13
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!walk_done && !mem_req));
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] cr0 = '0, cr3 = '0, cr4 = '0, a20_mask = 32'hFFFF_FFFF;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        walk_done, walk_fault, page_writable;
    logic [31:0] phys_page, fault_addr;
    logic [2:0]  fault_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_user(req_user), .cr0(cr0), .cr3(cr3),
        .cr4(cr4), .a20_mask(a20_mask), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .walk_done(walk_done), .walk_fault(walk_fault),
        .phys_page(phys_page), .page_writable(page_writable),
        .fault_code(fault_code), .fault_addr(fault_addr)
    );

    int n_chk = 0, n_bad = 0;
    int lat = 0, wcnt = 0;
    bit walk_open = 0;
    string cur_tag = "";

    logic [31:0] mem     [logic [31:0]];
    logic [31:0] exp_mem [logic [31:0]];
    logic [63:0] wq [$];

    bit          e_fault, e_wok;
    logic [2:0]  e_code;
    logic [31:0] e_phys;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] erd(input logic [31:0] a);
        return exp_mem.exists(a) ? exp_mem[a] : 32'h0;
    endfunction

    function automatic bit rights_deny(input logic [31:0] eff, input bit w, input bit u);
        if (u) return !eff[2] || (w && !eff[1]);
        return cr0[16] && w && !eff[1];
    endfunction

    function automatic bit rights_wr(input logic [31:0] eff, input bit u);
        if (u) return eff[1];
        return !cr0[16] || eff[1];
    endfunction

    task automatic expect_wr(input logic [31:0] a, input logic [31:0] d);
        wq.push_back({a, d});
        exp_mem[a] = d;
    endtask

    // behavioural reference of one translation
    task automatic model(input logic [31:0] a, input bit w, input bit u);
        logic [31:0] da, de, ta, te, eff, nv;
        exp_mem = mem;
        wq.delete();
        e_fault = 0; e_wok = 0; e_phys = 0; e_code = {u, w, 1'b0};
        if (!cr0[31]) begin
            e_phys = a & a20_mask & 32'hFFFF_F000;
            e_wok  = 1;
            return;
        end
        da = ((cr3 & 32'hFFFF_F000) + (a >> 22) * 4) & a20_mask;
        de = erd(da);
        if (!de[0]) begin e_fault = 1; return; end
        if (de[7] && cr4[4]) begin
            if (rights_deny(de, w, u)) begin e_fault = 1; e_code[0] = 1; return; end
            nv = de | 32'h20 | (w ? 32'h40 : 32'h0);
            if (nv != de) expect_wr(da, nv);
            e_phys = ((de & 32'hFFC0_0000) & a20_mask) + (((a >> 12) & 32'h3FF) << 12);
            e_wok  = nv[6] && rights_wr(de, u);
            return;
        end
        nv = de | 32'h20;
        if (nv != de) expect_wr(da, nv);
        ta = ((de & 32'hFFFF_F000) + ((a >> 12) & 32'h3FF) * 4) & a20_mask;
        te = erd(ta);
        if (!te[0]) begin e_fault = 1; return; end
        eff = te & de;
        if (rights_deny(eff, w, u)) begin e_fault = 1; e_code[0] = 1; return; end
        nv = te | 32'h20 | (w ? 32'h40 : 32'h0);
        if (nv != te) expect_wr(ta, nv);
        e_phys = te & a20_mask & 32'hFFFF_F000;
        e_wok  = nv[6] && rights_wr(eff, u);
    endtask

    // memory responder and per-clock comparison
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 0; wcnt = 0;
        end else begin
            if (walk_done && !walk_open)
                chk(0, "R12", "done without request", 32'h1, 32'h0);
            if (mem_ack) begin
                mem_ack = 0; wcnt = 0;
            end else if (mem_req) begin
                if (wcnt >= lat) begin
                    mem_ack = 1;
                    if (mem_we) begin
                        if (wq.size() == 0) begin
                            chk(0, cur_tag, "unexpected write-back (R8)", mem_addr, 32'h0);
                        end else begin
                            chk(wq[0][63:32] == mem_addr, cur_tag, "write-back address (R2/R8)",
                                mem_addr, wq[0][63:32]);
                            chk(wq[0][31:0] == mem_wdata, cur_tag, "write-back data (R8/R9)",
                                mem_wdata, wq[0][31:0]);
                            void'(wq.pop_front());
                        end
                        mem[mem_addr] = mem_wdata;
                    end else begin
                        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                    end
                end else begin
                    wcnt++;
                end
            end
        end
    end

    task automatic walk(input logic [31:0] a, input bit w, input bit u,
                        input bit poke, input string tag);
        bit got;
        cur_tag = tag;
        model(a, w, u);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_write = w; req_user = u;
        walk_open = 1;
        @(negedge clk);
        if (poke) begin
            req_addr = a ^ 32'h5555_5000;
            req_write = !w;
        end else begin
            req_valid = 0;
        end
        got = 0;
        for (int i = 0; i < 300 && !got; i++) begin
            if (walk_done) got = 1;
            else @(negedge clk);
        end
        req_valid = 0;
        if (!got) begin
            chk(0, tag, "watchdog: no completion", 32'h0, 32'h1);
        end else begin
            chk(walk_fault == e_fault, tag, "fault flag", {31'b0, walk_fault}, {31'b0, e_fault});
            if (e_fault) begin
                chk(fault_code == e_code, tag, "fault code (R7)", {29'b0, fault_code}, {29'b0, e_code});
                chk(fault_addr == a, tag, "fault address (R7)", fault_addr, a);
            end else begin
                chk(phys_page == e_phys, tag, "physical page", phys_page, e_phys);
                chk(page_writable == e_wok, tag, "write permission (R10)",
                    {31'b0, page_writable}, {31'b0, e_wok});
            end
            chk(wq.size() == 0, tag, "missing write-back (R8)", wq.size(), 32'h0);
        end
        @(negedge clk);
        walk_open = 0;
        chk(!walk_done, "R12", "done wider than one cycle", {31'b0, walk_done}, 32'h0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        chk(0, "ALL", "global watchdog expired", 32'h0, 32'h1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(!walk_done && !walk_fault, "R13", "done/fault in reset", {31'b0, walk_done}, 32'h0);
        chk(!mem_req, "R13", "mem_req in reset", {31'b0, mem_req}, 32'h0);
        rst = 0;
        @(negedge clk);
        chk(!walk_done && !mem_req, "R13", "idle after reset", {31'b0, mem_req}, 32'h0);

        // R1: paging off, identity map with A20 masking
        cr0 = 32'h0; cr3 = 32'h0010_0000; cr4 = 32'h10;
        walk(32'h1234_5678, 1, 1, 0, "R1");
        a20_mask = 32'hFFEF_FFFF;
        walk(32'h0017_3ABC, 0, 0, 0, "R1");
        a20_mask = 32'hFFFF_FFFF;

        cr0 = 32'h8000_0001;
        // R3: directory entry absent
        walk(32'h00C0_1000, 1, 1, 0, "R3");
        // R2/R8: clean 4 KB page read, both entries get accessed
        mem[32'h0010_0008] = 32'h0020_0007;
        mem[32'h0020_0014] = 32'h0030_0007;
        lat = 1;
        walk(32'h0080_5123, 0, 0, 0, "R8");
        // R9/R10: user write sets dirty in table entry only
        walk(32'h0080_5FFF, 1, 1, 0, "R9");
        // R8/R10: re-read dirty page, no write-back, writable
        lat = 2;
        walk(32'h0080_5000, 0, 1, 0, "R10");
        // R3: table entry absent
        walk(32'h0080_6000, 0, 0, 0, "R3");
        // R5: user blocked by directory U=0
        lat = 0;
        mem[32'h0010_000C] = 32'h0040_0003;
        mem[32'h0040_0000] = 32'h0050_0007;
        walk(32'h00C0_0000, 0, 1, 0, "R5");
        walk(32'h00C0_0000, 0, 0, 0, "R5");
        // R5: user write blocked by table RW=0
        mem[32'h0020_0018] = 32'h0060_0065;
        walk(32'h0080_6000, 1, 1, 0, "R5");
        walk(32'h0080_6000, 0, 1, 0, "R5");
        // R6: supervisor write to read-only page with and without WP
        cr0 = 32'h8001_0001;
        walk(32'h0080_6000, 1, 0, 0, "R6");
        cr0 = 32'h8000_0001;
        walk(32'h0080_6000, 1, 0, 0, "R6");
        // R4/R11: 4 MB page
        mem[32'h0010_0400] = 32'h0C00_0083;
        walk(32'h4012_3456, 1, 0, 0, "R11");
        walk(32'h403F_F000, 0, 1, 0, "R7");
        // R4: bit 7 ignored with large pages off
        cr4 = 32'h0;
        mem[32'h0C00_0000 + 32'h123 * 4] = 32'h0070_0001;
        walk(32'h4012_3456, 0, 0, 0, "R4");
        cr4 = 32'h10;
        // R2: A20 mask aliases directory base
        a20_mask = 32'hFFEF_FFFF;
        mem[32'h0000_0008] = 32'h0030_0001;
        mem[32'h0020_0004] = 32'h0031_0001;
        walk(32'h0080_1000, 0, 0, 0, "R2");
        a20_mask = 32'hFFFF_FFFF;
        // R12: req_valid held with other values during walk
        lat = 1;
        walk(32'h0080_5004, 0, 0, 1, "R12");
        walk(32'h4000_0000, 1, 1, 1, "R12");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule